// File: doc/BRIEF.md
# Microcoded Sequential Shift-Add Multiplier

This block multiplies two unsigned WIDTH-bit operands over several clock cycles using one WIDTH-bit adder. The operands arrive on one shared data input. A multiplicand strobe captures the value into a hidden operand register. A multiplier strobe captures it into the low half of the product register. A one-cycle start pulse then begins the multiplication. The 2*WIDTH-bit result is the concatenation of an accumulator (high half) and the multiplier register (low half). The multiplier bits are shifted out of that register while the product bits are shifted in.

Sequencing comes from a five-word, twelve-bit constant microprogram, not from hardwired next-state logic. Each word carries a taken and a not-taken address, a two-bit condition selector and four one-hot datapath strobes. The condition signals (start, multiplier LSB, counter-zero) only steer the choice of the next address. For this reason, adding the multiplicand is a separate microword that the sequencer branches to, and not an add that is gated by a condition.

`idle_o` is high whenever the sequencer sits at microaddress 0. While the block is idle, the product holds its value until the next run begins or a new multiplier is loaded.

Top module: `mpy_micro_top`

## Requirements
- R1: While `rst` is high and after its release, `idle_o` is 1 and `product_o` is 0.
- R2: After a run, once `idle_o` returns high, `product_o` equals the unsigned product of the last loaded multiplicand and multiplier, 2*WIDTH bits wide with no truncation.
- R3: A run lasts 2 + 2*WIDTH + popcount(multiplier) clock edges, counted from the edge that samples `start_i` high in idle up to the edge after which `idle_o` is high again. The run ends on the shift step in which the bit counter (preset to WIDTH-1) is zero.
- R4: `idle_o` goes low on the edge that samples `start_i` high in idle, and stays low for the whole run.
- R5: `start_i` asserted while a run is in progress has no effect on the result or on the run length.
- R6: While idle, with `start_i` and `ld_mplier_i` low, `product_o` does not change.
- R7: `ld_mcand_i` in idle leaves `product_o` unchanged. `ld_mplier_i` in idle places `din_i` into `product_o[WIDTH-1:0]` on the next edge and leaves the high half unchanged.
- R8: The initialise step clears the accumulator and the carry, so a previous result never leaks into a new one.
- R9: The microword layout is [11:9] taken address, [8:6] not-taken address, [5:4] condition (00 always, 01 start, 10 multiplier LSB, 11 counter zero; true selects the taken address), then the strobes init, add, clear-carry and shift. At most one of init, add and shift is active at a time. Every add step is immediately followed by a shift step, so that exactly one add occurs per 1 bit of the multiplier. The microaddress never leaves 0..4.
- R10: Extreme operands are exact, including all-ones times all-ones (the adder carry must be kept) and zero operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a multiplication; sampled only when idle |
| ld_mcand_i | input | 1 | Capture `din_i` as the multiplicand |
| ld_mplier_i | input | 1 | Capture `din_i` as the multiplier (product low half) |
| din_i | input | WIDTH | Shared operand input |
| product_o | output | 2*WIDTH | Accumulator and multiplier register, concatenated |
| idle_o | output | 1 | High while the sequencer is at microaddress 0 |

## Verification
A corrupted microword or a wrong condition select shows up at the ports at the end of the run, as a wrong product or a run length different from 2 + 2*WIDTH + popcount. Checking the exact edge count catches a skipped or doubled add step even when the product happens to match. A carry that is not captured or not cleared corrupts the high half of the result on the very next shift, and the all-ones operands expose this. A stale accumulator after initialisation appears in the first result of a back-to-back run. A sequencer that escapes idle shows as `idle_o` falling without a start, one edge later.

// File: rtl/mpy_ucode_pkg.sv
package mpy_ucode_pkg;

  localparam int UADDR_W = 3;
  localparam int UDEPTH  = 5;

  typedef enum logic [1:0] {
    COND_ALWAYS = 2'b00,
    COND_START  = 2'b01,
    COND_LSB    = 2'b10,
    COND_CNTZ   = 2'b11
  } cond_e;

  typedef struct packed {
    logic [UADDR_W-1:0] addr_t;   // taken when condition true
    logic [UADDR_W-1:0] addr_f;   // taken otherwise
    cond_e              cond;
    logic               init;     // clear acc and carry, preset counter
    logic               add;      // acc += mcand, carry captured
    logic               clr_c;    // clear carry
    logic               shift;    // {carry,acc,mplier} >> 1, counter - 1
  } uword_t;

  localparam logic [UADDR_W-1:0] UA_IDLE  = 3'd0;
  localparam logic [UADDR_W-1:0] UA_INIT  = 3'd1;
  localparam logic [UADDR_W-1:0] UA_TEST  = 3'd2;
  localparam logic [UADDR_W-1:0] UA_ADD   = 3'd3;
  localparam logic [UADDR_W-1:0] UA_SHIFT = 3'd4;

  function automatic uword_t ucode_word(input logic [UADDR_W-1:0] a);
    uword_t w;
    w = '{addr_t: UA_IDLE, addr_f: UA_IDLE, cond: COND_ALWAYS,
          init: 1'b0, add: 1'b0, clr_c: 1'b0, shift: 1'b0};
    case (a)
      UA_IDLE:  begin w.addr_t = UA_INIT;  w.addr_f = UA_IDLE;  w.cond = COND_START; end
      UA_INIT:  begin w.addr_f = UA_TEST;  w.init = 1'b1; end
      UA_TEST:  begin w.addr_t = UA_ADD;   w.addr_f = UA_SHIFT; w.cond = COND_LSB; end
      UA_ADD:   begin w.addr_f = UA_SHIFT; w.add = 1'b1; end
      UA_SHIFT: begin w.addr_t = UA_IDLE;  w.addr_f = UA_TEST;  w.cond = COND_CNTZ;
                      w.clr_c = 1'b1; w.shift = 1'b1; end
      default:  w.addr_f = UA_IDLE;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/mpy_ctrl_store.sv
module mpy_ctrl_store
  import mpy_ucode_pkg::*;
(
  input  logic [UADDR_W-1:0] uaddr,
  output uword_t             word
);
  always_comb word = ucode_word(uaddr);
endmodule

// File: rtl/mpy_sequencer.sv
module mpy_sequencer
  import mpy_ucode_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  uword_t             word,
  input  logic               start,
  input  logic               lsb,
  input  logic               cnt_zero,
  output logic [UADDR_W-1:0] uaddr
);
  logic               take;
  logic [UADDR_W-1:0] uaddr_nx;

  always_comb begin
    case (word.cond)
      COND_START: take = start;
      COND_LSB:   take = lsb;
      COND_CNTZ:  take = cnt_zero;
      default:    take = 1'b0;
    endcase
    uaddr_nx = take ? word.addr_t : word.addr_f;
  end

  always_ff @(posedge clk) begin
    if (rst) uaddr <= UA_IDLE;
    else     uaddr <= uaddr_nx;
  end
endmodule

// File: rtl/mpy_datapath.sv
module mpy_datapath #(
  parameter int WIDTH = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [WIDTH-1:0]   din,
  input  logic               ld_mcand,
  input  logic               ld_mplier,
  input  logic               do_init,
  input  logic               do_add,
  input  logic               do_clr_c,
  input  logic               do_shift,
  output logic [2*WIDTH-1:0] product,
  output logic               lsb,
  output logic               cnt_zero
);
  localparam int CW = (WIDTH < 2) ? 1 : $clog2(WIDTH);
  localparam logic [CW-1:0] CNT_PRESET = CW'(WIDTH - 1);

  logic [WIDTH-1:0] mcand_q, acc_q, mplier_q;
  logic             carry_q;
  logic [CW-1:0]    cnt_q;

  function automatic logic [WIDTH:0] add_step(input logic [WIDTH-1:0] a,
                                              input logic [WIDTH-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic [2*WIDTH:0] shift_step(input logic c,
                                                  input logic [WIDTH-1:0] a,
                                                  input logic [WIDTH-1:0] q);
    return {1'b0, c, a, q[WIDTH-1:1]};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q  <= '0;
      acc_q    <= '0;
      mplier_q <= '0;
      carry_q  <= 1'b0;
      cnt_q    <= '0;
    end else begin
      if (ld_mcand)  mcand_q  <= din;
      if (ld_mplier) mplier_q <= din;
      if (do_init) begin
        carry_q <= 1'b0;
        acc_q   <= '0;
        cnt_q   <= CNT_PRESET;
      end
      if (do_add)   {carry_q, acc_q} <= add_step(acc_q, mcand_q);
      if (do_clr_c) carry_q <= 1'b0;
      if (do_shift) begin
        {carry_q, acc_q, mplier_q} <= shift_step(carry_q, acc_q, mplier_q);
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign product  = {acc_q, mplier_q};
  assign lsb      = mplier_q[0];
  assign cnt_zero = (cnt_q == '0);
endmodule

// File: rtl/mpy_micro_top.sv
module mpy_micro_top
  import mpy_ucode_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               ld_mcand_i,
  input  logic               ld_mplier_i,
  input  logic [WIDTH-1:0]   din_i,
  output logic [2*WIDTH-1:0] product_o,
  output logic               idle_o
);
  logic [UADDR_W-1:0] uaddr;
  uword_t             uword;
  logic               lsb, cnt_zero;
  logic               do_init, do_add, do_clr_c, do_shift;

  mpy_ctrl_store i_store (.uaddr(uaddr), .word(uword));

  mpy_sequencer i_seq (
    .clk(clk), .rst(rst), .word(uword), .start(start_i),
    .lsb(lsb), .cnt_zero(cnt_zero), .uaddr(uaddr)
  );

  assign do_init  = uword.init;
  assign do_add   = uword.add;
  assign do_clr_c = uword.clr_c;
  assign do_shift = uword.shift;

  mpy_datapath #(.WIDTH(WIDTH)) i_dp (
    .clk(clk), .rst(rst), .din(din_i),
    .ld_mcand(ld_mcand_i), .ld_mplier(ld_mplier_i),
    .do_init(do_init), .do_add(do_add), .do_clr_c(do_clr_c), .do_shift(do_shift),
    .product(product_o), .lsb(lsb), .cnt_zero(cnt_zero)
  );

  assign idle_o = (uaddr == UA_IDLE);
endmodule

// File: rtl/mpy_micro_chk.sv
module mpy_micro_chk #(
  parameter int WIDTH = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               start_i,
  input logic               ld_mplier_i,
  input logic               idle_o,
  input logic [2*WIDTH-1:0] product_o,
  input logic [2:0]         uaddr,
  input logic               do_init,
  input logic               do_add,
  input logic               do_shift,
  input logic               cnt_zero
);
  // R3
  last_shift_ends_chk: assert property (@(posedge clk) disable iff (rst)
    do_shift && cnt_zero |=> idle_o);

  // R4
  start_leaves_idle_chk: assert property (@(posedge clk) disable iff (rst)
    idle_o && start_i |=> !idle_o);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    idle_o && !start_i && !ld_mplier_i |=> $stable(product_o));

  // R8
  init_clears_chk: assert property (@(posedge clk) disable iff (rst)
    do_init |=> product_o[2*WIDTH-1:WIDTH] == '0);

  // R9
  add_then_shift_chk: assert property (@(posedge clk) disable iff (rst)
    do_add |=> do_shift);

  // R9
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({do_init, do_add, do_shift}));

  // R9
  uaddr_range_chk: assert property (@(posedge clk) disable iff (rst)
    uaddr < 3'd5);
endmodule

bind mpy_micro_top mpy_micro_chk #(.WIDTH(WIDTH)) i_mpy_micro_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .ld_mplier_i(ld_mplier_i),
  .idle_o(idle_o), .product_o(product_o), .uaddr(uaddr),
  .do_init(do_init), .do_add(do_add), .do_shift(do_shift), .cnt_zero(cnt_zero)
);

// File: tb/test_mpy_micro_top.sv
module test_mpy_micro_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  int   n_checks = 0;
  int   n_errors = 0;
  bit   finished = 1'b0;

  logic        s4 = 0, lb4 = 0, lq4 = 0;
  logic [3:0]  d4 = '0;
  logic [7:0]  p4;
  logic        idle4;
  logic        s8 = 0, lb8 = 0, lq8 = 0;
  logic [7:0]  d8 = '0;
  logic [15:0] p8;
  logic        idle8;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpy_micro_top #(.WIDTH(4)) i_mpy_micro_top (
    .clk(clk), .rst(rst), .start_i(s4), .ld_mcand_i(lb4), .ld_mplier_i(lq4),
    .din_i(d4), .product_o(p4), .idle_o(idle4));

  mpy_micro_top #(.WIDTH(8)) i_mpy_micro_top_w8 (
    .clk(clk), .rst(rst), .start_i(s8), .ld_mcand_i(lb8), .ld_mplier_i(lq8),
    .din_i(d8), .product_o(p8), .idle_o(idle8));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] prod(input bit wide);
    return wide ? p8 : {8'h00, p4};
  endfunction

  function automatic bit idle(input bit wide);
    return wide ? idle8 : idle4;
  endfunction

  task automatic set_start(input bit wide, input logic v);
    if (wide) s8 = v; else s4 = v;
  endtask

  task automatic load(input bit wide, input logic [7:0] mc, input logic [7:0] mp);
    @(negedge clk);
    if (wide) begin d8 = mc; lb8 = 1; end else begin d4 = mc[3:0]; lb4 = 1; end
    @(negedge clk);
    lb4 = 0; lb8 = 0;
    if (wide) begin d8 = mp; lq8 = 1; end else begin d4 = mp[3:0]; lq4 = 1; end
    @(negedge clk);
    lq4 = 0; lq8 = 0;
  endtask

  // one full run; optional start poke while busy (R5)
  task automatic do_mul(input bit wide, input logic [7:0] mc, input logic [7:0] mp,
                        input bit poke, input string tag);
    int w = wide ? 8 : 4;
    int cnt;
    int exp_lat;
    logic [15:0] exp_p;
    load(wide, mc, mp);
    exp_p   = 16'(mc) * 16'(mp);
    exp_lat = 2 + 2*w + $countones(wide ? mp : {4'h0, mp[3:0]});
    set_start(wide, 1'b1);
    @(negedge clk);
    set_start(wide, 1'b0);
    cnt = 1;
    check(!idle(wide), {tag, " R4 busy after start"}, int'(idle(wide)), 0);
    while (!idle(wide) && cnt < 200) begin
      @(negedge clk);
      cnt++;
      if (!idle(wide) && cnt < 200)
        check(!idle(wide) || cnt >= exp_lat, {tag, " R4 stays busy"}, int'(idle(wide)), 0);
      set_start(wide, poke && (cnt == 3 || cnt == 6));
    end
    set_start(wide, 1'b0);
    check(prod(wide) == exp_p, {tag, " R2 product"}, int'(prod(wide)), int'(exp_p));
    check(cnt == exp_lat, {tag, " R3 R9 run length"}, cnt, exp_lat);
  endtask

  task automatic t_reset;
    check(idle4 && idle8, "R1 idle after reset", int'({idle8, idle4}), 3);
    check(p4 == 0 && p8 == 0, "R1 product zero after reset", int'(p8) + int'(p4), 0);
  endtask

  task automatic t_exhaustive4;
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        do_mul(1'b0, 8'(a), 8'(b), 1'b0, "R2 w4 sweep");
  endtask

  task automatic t_random8;
    for (int i = 0; i < 60; i++)
      do_mul(1'b1, 8'($urandom), 8'($urandom), 1'b0, "R2 w8 random");
  endtask

  task automatic t_edges;
    do_mul(1'b1, 8'hFF, 8'hFF, 1'b0, "R10 w8 max*max");
    do_mul(1'b1, 8'h00, 8'hFF, 1'b0, "R10 w8 zero mcand");
    do_mul(1'b1, 8'hFF, 8'h00, 1'b0, "R10 w8 zero mplier");
    do_mul(1'b0, 8'h0F, 8'h0F, 1'b0, "R10 w4 max*max");
  endtask

  task automatic t_busy_start;
    do_mul(1'b0, 8'h0B, 8'h0D, 1'b1, "R5 w4 start while busy");
    do_mul(1'b1, 8'hC3, 8'h5A, 1'b1, "R5 w8 start while busy");
  endtask

  task automatic t_idle_hold;
    logic [15:0] held;
    do_mul(1'b1, 8'h9E, 8'h37, 1'b0, "R6 setup");
    held = prod(1'b1);
    repeat (12) @(negedge clk);
    check(idle8 == 1'b1, "R6 stays idle without start", int'(idle8), 1);
    check(prod(1'b1) == held, "R6 product held in idle", int'(prod(1'b1)), int'(held));
  endtask

  task automatic t_load_idle;
    logic [15:0] held;
    held = prod(1'b1);
    @(negedge clk); d8 = 8'hA5; lb8 = 1;
    @(negedge clk); lb8 = 0;
    check(prod(1'b1) == held, "R7 mcand load hidden", int'(prod(1'b1)), int'(held));
    d8 = 8'h3C; lq8 = 1;
    @(negedge clk); lq8 = 0;
    check(p8[7:0] == 8'h3C, "R7 mplier load low half", int'(p8[7:0]), 8'h3C);
    check(p8[15:8] == held[15:8], "R7 mplier load high half kept",
          int'(p8[15:8]), int'(held[15:8]));
  endtask

  task automatic t_back_to_back;
    do_mul(1'b0, 8'h0F, 8'h0F, 1'b0, "R8 first");
    do_mul(1'b0, 8'h01, 8'h01, 1'b0, "R8 acc cleared");
    check(p4 == 8'h01, "R8 no leak", int'(p4), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_exhaustive4();
    t_random8();
    t_edges();
    t_busy_start();
    t_idle_hold();
    t_load_idle();
    t_back_to_back();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule